// File: doc/BRIEF.md
# Keyed-Access Watchdog with NMI Escalation

This block is a watchdog counter for an embedded controller. It stays idle after power-on until software configures it. Configuration is accepted once per reset, and only after an unlock pair of key writes to the control register. That one configuration may enable the counter and choose its timeout length and timeout action. It may also leave the watchdog off for good.

A running watchdog is held off by a second, separate key pair that restarts the count. Single stray writes therefore cannot keep it quiet. When the count expires, the block pulses either a non-maskable interrupt request or a system reset request. In interrupt mode a sticky interrupt flag is set. If a further timeout arrives while that flag is still set, the block requests a system reset rather than raising a second interrupt.

A reset-cause flag records every reset the watchdog requests. That flag is cleared only by power-on reset or by an access to the control register. It survives the system reset, so start-up code can read it afterwards. The register bus is a plain strobe interface that never stalls. Writes complete in the cycle of the strobe, and read data arrives one cycle after the read strobe.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset or system reset, the watchdog is disabled and unlocked, the tap is 0, the NMI flag is clear, and both request outputs are low. Only power-on reset clears the reset-cause flag.
- R2: Three writes to the control address configure the watchdog: 16'h3333, then 16'hCCCC, then a data word. The data word sets enable (bit 15), action (bit 14, 1 = reset, 0 = NMI) and tap (bits 3:0). It also sets the lock bit (bit 13).
- R3: Any write between the keys aborts the sequence. This includes a wrong value, a write to another address, or a non-key first write. The following data write is then ignored.
- R4: Once locked, further keyed data writes leave enable, action and tap unchanged until a reset. This holds even when the locked configuration has the watchdog disabled.
- R5: The timeout period is 2^E clocks, where E = MIN_EXP + tap, clamped to MAX_EXP. The request pulse appears 2^E cycles after the edge that restarted the count.
- R6: Writing 16'hAAAA then 16'h5555 to the control address restarts the count. If another write comes between the two, nothing is restarted.
- R7: In NMI mode, a timeout with the NMI flag clear gives a one-cycle NMI pulse and sets the NMI flag (bit 12).
- R8: A timeout while the NMI flag is set gives a one-cycle system reset request and no NMI.
- R9: In reset mode, every timeout gives a one-cycle system reset request.
- R10: The NMI flag is cleared only by a keyed data write with bit 12 set. A plain write of the same value leaves it set.
- R11: Each reset request sets the reset-cause flag (bit 11). The flag survives system reset and is cleared by any read or write of the control address.
- R12: Reading the control address returns the register view one cycle later. Reads between key writes do not disturb the sequence.
- R13: The NMI and reset request outputs are never high in the same cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous, clears everything |
| sys_rst_n | input | 1 | System reset, active low, synchronous, keeps the reset-cause flag |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd, zero otherwise |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A request pulse is due exactly 2^E cycles after the clock edge that took the final kick key or the enabling data word. Read data is due one cycle after the read strobe, and a configuration or flag change shows in any read issued after the edge that made it. The bench drives inputs and samples outputs on falling edges. Its per-cycle reference model applies every write at the same rising edge as the design. Directed period measurements count falling edges from the first edge after the restart, so a result of 2^E means the pulse landed in the cycle the requirement predicts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 16;

  localparam logic [DW-1:0] KEY_CFG_A  = 16'h3333;
  localparam logic [DW-1:0] KEY_CFG_B  = 16'hCCCC;
  localparam logic [DW-1:0] KEY_KICK_A = 16'hAAAA;
  localparam logic [DW-1:0] KEY_KICK_B = 16'h5555;

  // register view and data-word field positions
  localparam int B_EN     = 15;
  localparam int B_ACT    = 14;
  localparam int B_LOCK   = 13;
  localparam int B_NMIF   = 12;
  localparam int B_RSTF   = 11;
  localparam int B_NMICLR = 12;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CFG_HALF,
    SQ_CFG_OPEN,
    SQ_KICK_HALF
  } seq_t;
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          hit,
  input  logic [DW-1:0] wd,
  output logic          cfg_stb,
  output logic          kick_stb
);

  seq_t st, st_nx;

  always_comb begin
    st_nx    = st;
    cfg_stb  = 1'b0;
    kick_stb = 1'b0;
    if (wr) begin
      if (!hit) begin
        st_nx = SQ_IDLE;
      end else begin
        case (st)
          SQ_IDLE: begin
            if (wd == KEY_CFG_A)       st_nx = SQ_CFG_HALF;
            else if (wd == KEY_KICK_A) st_nx = SQ_KICK_HALF;
            else                       st_nx = SQ_IDLE;
          end
          SQ_CFG_HALF: begin
            st_nx = (wd == KEY_CFG_B) ? SQ_CFG_OPEN : SQ_IDLE;
          end
          SQ_CFG_OPEN: begin
            cfg_stb = 1'b1;
            st_nx   = SQ_IDLE;
          end
          SQ_KICK_HALF: begin
            kick_stb = (wd == KEY_KICK_B);
            st_nx    = SQ_IDLE;
          end
          default: st_nx = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SQ_IDLE;
    else     st <= st_nx;
  end

  // R3: a wrong second key drops the sequence back to idle
  assert_bad_key_aborts_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && hit && st == SQ_CFG_HALF && wd != KEY_CFG_B) |=> (st == SQ_IDLE));

  // R3: a write to another address always aborts
  assert_foreign_write_aborts_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && !hit) |=> (st == SQ_IDLE));

  // R12: reads and idle cycles leave the sequence where it is
  assert_idle_holds_state_R12: assert property (@(posedge clk) disable iff (rst)
    (!wr) |=> $stable(st));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int MIN_EXP = 11,
  parameter int MAX_EXP = 26,
  parameter int TAP_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             kick,
  input  logic [TAP_W-1:0] tap,
  output logic             tmo
);

  localparam int CW = MAX_EXP;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_mask;
  int            exp_sel;

  always_comb begin
    exp_sel = MIN_EXP + int'(tap);
    if (exp_sel > MAX_EXP) exp_sel = MAX_EXP;
  end

  // terminal count: low exp_sel bits set
  for (genvar g = 0; g < CW; g++) begin : g_mask
    assign lim_mask[g] = (g < exp_sel);
  end

  assign tmo = run && !kick && (cnt == lim_mask);

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (!run || kick || tmo) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  // R6: a kick always restarts from zero
  assert_kick_restarts_R6: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == '0));

  // R5: below the terminal count the counter advances by one
  assert_count_advances_R5: assert property (@(posedge clk) disable iff (rst)
    (run && !kick && cnt != lim_mask) |=> (cnt == $past(cnt) + 1'b1));

  // R1: a stopped watchdog holds zero
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (cnt == '0));

endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk,
  input  logic por_rst,
  input  logic sys_rst,
  input  logic tmo,
  input  logic act_rst,
  input  logic clr_stb,
  input  logic access,
  output logic nmi_o,
  output logic rst_req_o,
  output logic nmi_flag,
  output logic rst_flag
);

  logic escalate;
  assign escalate = act_rst || nmi_flag;

  always_ff @(posedge clk) begin
    if (por_rst || sys_rst) begin
      nmi_o     <= 1'b0;
      rst_req_o <= 1'b0;
      nmi_flag  <= 1'b0;
    end else begin
      nmi_o     <= tmo && !escalate;
      rst_req_o <= tmo && escalate;
      if (tmo && !escalate) nmi_flag <= 1'b1;
      else if (clr_stb)     nmi_flag <= 1'b0;
    end
  end

  // cause flag: only power-on clears it by reset
  always_ff @(posedge clk) begin
    if (por_rst) begin
      rst_flag <= 1'b0;
    end else if (!sys_rst) begin
      if (tmo && escalate) rst_flag <= 1'b1;
      else if (access)     rst_flag <= 1'b0;
    end
  end

  assert_never_both_R13: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    !(nmi_o && rst_req_o));

  assert_nmi_single_cycle_R13: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    nmi_o |=> !nmi_o);

  assert_nmi_sets_flag_R7: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    nmi_o |-> nmi_flag);

  assert_escalates_R8: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (tmo && nmi_flag) |=> (rst_req_o && !nmi_o));

  assert_reset_mode_R9: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (tmo && act_rst) |=> rst_req_o);

  assert_cause_recorded_R11: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    rst_req_o |-> rst_flag);

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter int              MIN_EXP   = 11,
  parameter int              MAX_EXP   = 26,
  parameter int              TAP_W     = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              nmi_req,
  output logic              sys_rst_req
);

  logic             por_rst, sys_rst, rst_all;
  logic             hit, cfg_stb, kick_stb, tmo, access;
  logic             cfg_en, cfg_act, cfg_lock;
  logic [TAP_W-1:0] cfg_tap;
  logic             nmi_flag, rst_flag;
  logic [DW-1:0]    reg_view;

  assign por_rst = !por_n;
  assign sys_rst = !sys_rst_n;
  assign rst_all = por_rst || sys_rst;
  assign hit     = (bus_addr == CTRL_ADDR);
  assign access  = hit && (bus_wr || bus_rd);

  wdt_keyseq u_seq (
    .clk      (clk),
    .rst      (rst_all),
    .wr       (bus_wr),
    .hit      (hit),
    .wd       (bus_wdata),
    .cfg_stb  (cfg_stb),
    .kick_stb (kick_stb)
  );

  wdt_counter #(
    .MIN_EXP (MIN_EXP),
    .MAX_EXP (MAX_EXP),
    .TAP_W   (TAP_W)
  ) u_cnt (
    .clk  (clk),
    .rst  (rst_all),
    .run  (cfg_en),
    .kick (kick_stb),
    .tap  (cfg_tap),
    .tmo  (tmo)
  );

  wdt_flags u_flg (
    .clk       (clk),
    .por_rst   (por_rst),
    .sys_rst   (sys_rst),
    .tmo       (tmo),
    .act_rst   (cfg_act),
    .clr_stb   (cfg_stb && bus_wdata[B_NMICLR]),
    .access    (access),
    .nmi_o     (nmi_req),
    .rst_req_o (sys_rst_req),
    .nmi_flag  (nmi_flag),
    .rst_flag  (rst_flag)
  );

  // one-shot configuration
  always_ff @(posedge clk) begin
    if (rst_all) begin
      cfg_en   <= 1'b0;
      cfg_act  <= 1'b0;
      cfg_lock <= 1'b0;
      cfg_tap  <= '0;
    end else if (cfg_stb && !cfg_lock) begin
      cfg_en   <= bus_wdata[B_EN];
      cfg_act  <= bus_wdata[B_ACT];
      cfg_tap  <= bus_wdata[TAP_W-1:0];
      cfg_lock <= 1'b1;
    end
  end

  always_comb begin
    reg_view              = '0;
    reg_view[B_EN]        = cfg_en;
    reg_view[B_ACT]       = cfg_act;
    reg_view[B_LOCK]      = cfg_lock;
    reg_view[B_NMIF]      = nmi_flag;
    reg_view[B_RSTF]      = rst_flag;
    reg_view[TAP_W-1:0]   = cfg_tap;
  end

  always_ff @(posedge clk) begin
    if (rst_all)              bus_rdata <= '0;
    else if (bus_rd && hit)   bus_rdata <= reg_view;
    else                      bus_rdata <= '0;
  end

  assert_lock_freezes_R4: assert property (@(posedge clk) disable iff (rst_all)
    cfg_lock |=> (cfg_lock && $stable(cfg_en) && $stable(cfg_act) && $stable(cfg_tap)));

  assert_sysrst_disables_R1: assert property (@(posedge clk) disable iff (por_rst)
    sys_rst |=> (!cfg_en && !cfg_lock && !nmi_req && !sys_rst_req));

  assert_no_stray_data_R12: assert property (@(posedge clk) disable iff (rst_all)
    !(bus_rd && hit) |=> (bus_rdata == '0));

endmodule

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;
  localparam int AW = 4, MINE = 4, MAXE = 8, TW = 4;
  localparam logic [AW-1:0] CA = 4'h2, OTHER = 4'h5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          por_n = 1'b0, sys_rst_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0]   bus_rdata;
  logic          nmi_req, sys_rst_req;

  int checks = 0, failures = 0;
  int n_nmi = 0, n_rst = 0;
  bit cmp_on = 1'b0;

  wdt_keyed #(.ADDR_W(AW), .CTRL_ADDR(CA), .MIN_EXP(MINE), .MAX_EXP(MAXE), .TAP_W(TW)) uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .nmi_req(nmi_req), .sys_rst_req(sys_rst_req));

  // behavioural reference model
  bit m_en, m_act, m_lock, m_nmif, m_rstf, m_nmi, m_rst;
  int m_tap, m_cnt, m_seq;
  logic [15:0] m_rdata;
  bit wc, rc, cfg, kick, tmo, esc;
  int e, lim;
  logic [15:0] nrd;

  always @(posedge clk) begin
    if (!por_n || !sys_rst_n) begin
      if (!por_n) m_rstf = 0;
      m_en = 0; m_act = 0; m_lock = 0; m_nmif = 0; m_tap = 0;
      m_cnt = 0; m_seq = 0; m_rdata = 0; m_nmi = 0; m_rst = 0;
    end else begin
      wc = bus_wr && bus_addr == CA;
      rc = bus_rd && bus_addr == CA;
      cfg = 0; kick = 0; tmo = 0;
      nrd = 16'h0;
      if (rc) begin
        nrd[15] = m_en; nrd[14] = m_act; nrd[13] = m_lock;
        nrd[12] = m_nmif; nrd[11] = m_rstf; nrd[3:0] = m_tap[3:0];
      end
      if (bus_wr) begin
        if (!wc) m_seq = 0;
        else if (m_seq == 0) m_seq = (bus_wdata == 16'h3333) ? 1 : (bus_wdata == 16'hAAAA) ? 3 : 0;
        else if (m_seq == 1) m_seq = (bus_wdata == 16'hCCCC) ? 2 : 0;
        else if (m_seq == 2) begin cfg = 1; m_seq = 0; end
        else begin kick = (bus_wdata == 16'h5555); m_seq = 0; end
      end
      e = MINE + m_tap;
      if (e > MAXE) e = MAXE;
      lim = 1 << e;
      if (!m_en || kick) m_cnt = 0;
      else if (m_cnt == lim - 1) begin tmo = 1; m_cnt = 0; end
      else m_cnt++;
      esc = m_act || m_nmif;
      m_nmi = tmo && !esc;
      m_rst = tmo && esc;
      if (m_nmi) m_nmif = 1;
      else if (cfg && bus_wdata[12]) m_nmif = 0;
      if (m_rst) m_rstf = 1;
      else if (wc || rc) m_rstf = 0;
      if (cfg && !m_lock) begin
        m_en = bus_wdata[15]; m_act = bus_wdata[14]; m_tap = int'(bus_wdata[3:0]); m_lock = 1;
      end
      m_rdata = nrd;
    end
  end

  always @(negedge clk) begin
    if (nmi_req) n_nmi++;
    if (sys_rst_req) n_rst++;
    if (cmp_on) begin
      checks++;
      if (nmi_req !== m_nmi || sys_rst_req !== m_rst || bus_rdata !== m_rdata) begin
        failures++;
        $display("FAIL R13 model: nmi=%0b rst=%0b rdata=%h expected nmi=%0b rst=%0b rdata=%h",
                 nmi_req, sys_rst_req, bus_rdata, m_nmi, m_rst, m_rdata);
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(output logic [15:0] v);
    bus_addr = CA; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic keyed(input logic [15:0] d);
    wr(CA, 16'h3333); wr(CA, 16'hCCCC); wr(CA, d);
  endtask

  task automatic kick_it();
    wr(CA, 16'hAAAA); wr(CA, 16'h5555);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sysrst();
    sys_rst_n = 1'b0; idle(2); sys_rst_n = 1'b1;
  endtask

  // cycles until a request pulse; kind 1 = nmi, 2 = reset
  task automatic measure(output int n, output int kind);
    n = 0; kind = 0;
    while (kind == 0 && n < 2000) begin
      @(negedge clk); n++;
      if (nmi_req) kind = 1;
      else if (sys_rst_req) kind = 2;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n, kind, base;
    idle(3);
    por_n = 1'b1;
    cmp_on = 1'b1;
    idle(1);
    rd(v); chk("R1 reset view", v, 0);
    chk("R1 no requests", {nmi_req, sys_rst_req}, 0);

    // R3: broken unlock sequences
    wr(CA, 16'h3333); wr(OTHER, 16'hCCCC); wr(CA, 16'hCCCC); wr(CA, 16'h8002);
    rd(v); chk("R3 foreign write aborts", v, 0);
    wr(CA, 16'h3333); wr(CA, 16'h1111); wr(CA, 16'h8002);
    rd(v); chk("R3 wrong key aborts", v, 0);

    // R2 / R12: read between keys does not disturb
    wr(CA, 16'h3333); rd(v); chk("R12 read mid-sequence", v, 0);
    wr(CA, 16'hCCCC); wr(CA, 16'h8002);
    rd(v); chk("R2 configured view", v, 16'hA002);

    // R4: second configuration ignored
    keyed(16'h4005);
    rd(v); chk("R4 locked config", v, 16'hA002);

    // R5 / R7: NMI after 64 cycles
    kick_it();
    measure(n, kind);
    chk("R5 period tap2", n, 64);
    chk("R7 nmi kind", kind, 1);
    @(negedge clk); chk("R13 one-cycle pulse", {nmi_req, sys_rst_req}, 0);
    rd(v); chk("R7 nmi flag", v, 16'hB002);

    // R6: regular kicks hold it off
    base = n_nmi + n_rst;
    for (int i = 0; i < 5; i++) begin idle(38); kick_it(); end
    chk("R6 kicks prevent timeout", n_nmi + n_rst, base);
    wr(CA, 16'hAAAA); wr(OTHER, 16'h0000); wr(CA, 16'h5555);
    measure(n, kind);
    chk("R6 broken kick ignored", n, 61);
    chk("R8 escalated to reset", kind, 2);

    // R11: cause flag survives system reset, read clears
    sysrst();
    rd(v); chk("R11 flag after sys reset", v, 16'h0800);
    rd(v); chk("R11 read clears", v, 0);

    // R10: flag clear only through keyed write
    keyed(16'h8001);
    kick_it();
    measure(n, kind);
    chk("R5 period tap1", n, 32);
    chk("R7 nmi again", kind, 1);
    rd(v); chk("R10 flag set", v, 16'hB001);
    wr(CA, 16'h1000);
    rd(v); chk("R10 plain write no clear", v, 16'hB001);
    keyed(16'h1000);
    rd(v); chk("R10 keyed clear", v, 16'hA001);
    measure(n, kind);
    chk("R10 next timeout is nmi", kind, 1);

    // R9 / R5 clamp: reset mode, tap7 clamps to 2^8
    sysrst();
    keyed(16'hC007);
    rd(v); chk("R9 reset-mode view", v, 16'hE007);
    kick_it();
    measure(n, kind);
    chk("R5 clamped period", n, 256);
    chk("R9 reset request", kind, 2);
    wr(CA, 16'h0000);
    rd(v); chk("R11 write clears", v, 16'hE007);

    // R4: locked disabled
    sysrst();
    keyed(16'h0003);
    keyed(16'h8000);
    rd(v); chk("R4 locked off", v, 16'h2003);
    base = n_nmi + n_rst;
    idle(300);
    chk("R4 stays silent", n_nmi + n_rst, base);

    // R1: power-on reset clears everything
    por_n = 1'b0; idle(2); por_n = 1'b1;
    rd(v); chk("R1 por view", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule